// File: doc/BRIEF.md
# Dual Reload Pulse Generator

This block produces pulse-width-modulated outputs from a pair of down-counters. Each counter has two reload values, one for the time the output spends low and one for the time it spends high. A period begins with the low phase. At the end of each phase the counter reloads from the value for the next phase, so low time and high time are set independently of each other. Both counters share one count clock. It is the system clock divided by a power of two chosen in a configuration register.

The pair runs in one of three arrangements. In split mode the two counters are separate 8-bit generators, each with its own output. In wide mode they join into one 16-bit generator whose widths come from the two channels' reload bytes placed side by side. In prescaled mode the first counter becomes a programmable divider that paces the second counter. Every completed period sets a sticky flag, and the flag can raise an interrupt. Software reaches all registers through a small synchronous bus with one-cycle read latency.

Top module: `ppg_top`

## Requirements
- R1: After reset every register reads 0, both pulse outputs are low and both interrupt outputs are low.
- R2: Register map (3-bit address): 0 = control {mode[5:4], outEnable1[3], outEnable0[2], enable1[1], enable0[0]}; 1 = config {irqEnable1[4], irqEnable0[3], clockSelect[2:0]}; 2 = low width 0; 3 = high width 0; 4 = low width 1; 5 = high width 1; 6 = flags {flag1[1], flag0[0]}. Unused control and config bits read 0. Read data appears on the cycle after the address is presented.
- R3: In split mode (mode 0, and mode 3 acts the same) each counter drives its own output. The output is low for (low+1) ticks and high for (high+1) ticks, and both channels run at once without affecting each other.
- R4: In wide mode (mode 1), enabled by enable1, output 1 is low for ({low1,low0}+1) ticks and high for ({high1,high0}+1) ticks. Output 0 stays low.
- R5: In prescaled mode (mode 2), enabled by enable1, one tick of counter 1 takes (low0+1) count ticks. Output 1 is low for (low1+1)(low0+1) ticks and high for (high1+1)(low0+1) ticks.
- R6: A count tick lasts 1, 2, 4, 8 or 16 clock cycles for clock-select codes 0 to 4. Codes 5 to 7 act as 16.
- R7: After a channel is enabled its output starts in the low phase. Clearing the enable forces the output low within two clock cycles.
- R8: With the output enable clear, the pulse output stays low while the counter still runs and still sets its period flag.
- R9: A high width written during the low phase takes effect from the following period. The high phase that follows the write still uses the old value.
- R10: Each completed period sets its flag. Writing 1 to a flag bit clears it. An interrupt output equals its flag ANDed with its interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| pwmOut0 | output | 1 | Pulse output of channel 0 |
| pwmOut1 | output | 1 | Pulse output of channel 1 or of the joined pair |
| irq0 | output | 1 | Period interrupt of channel 0 |
| irq1 | output | 1 | Period interrupt of channel 1 or of the joined pair |

## Verification
The assertions assume that software leaves the clock-select code unchanged while a tick is pending. They also assume that the mode field changes only when both counters are disabled, because the spacing between ticks and the idle state of output 0 follow from those settings. The stimulus meets this: every test first writes a zero control word and only then loads the configuration, the widths and a new mode together with the enables. Widths are measured edge to edge in steady periods, so the phase of the free-running divider at enable time does not enter any expected value.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOW0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HIGH0 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LOW1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_HIGH1 = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd6;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_PRESC = 2'd2,
    MODE_RSVD  = 2'd3
  } ppgMode_e;

  typedef struct packed {
    logic     run0;
    logic     run1;
    logic     oe0;
    logic     oe1;
    logic     baseTick;
    ppgMode_e mode;
    logic     wrLow0;
    logic     wrHigh0;
    logic     wrLow1;
    logic     wrHigh1;
  } ppgStrobe_t;

endpackage

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] lowVal,
  input  logic [W-1:0] highVal,
  output logic         level,
  output logic         periodDone
);

  logic         active;
  logic         phaseHigh;
  logic [W-1:0] cnt;
  logic [W-1:0] highHold;
  logic         atZero;

  assign atZero     = (cnt == '0);
  assign periodDone = run && active && tick && phaseHigh && atZero;
  assign level      = phaseHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      phaseHigh <= 1'b0;
      cnt       <= '0;
      highHold  <= '0;
    end else if (!run) begin
      active    <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (!active) begin
      active    <= 1'b1;
      phaseHigh <= 1'b0;
      cnt       <= lowVal;
      highHold  <= highVal;
    end else if (tick) begin
      if (atZero) begin
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
          cnt       <= highHold;
        end else begin
          phaseHigh <= 1'b0;
          cnt       <= lowVal;
          highHold  <= highVal;
        end
      end else begin
        cnt <= cnt - W'(1);
      end
    end
  end

  // R7: a stopped counter drops its level on the next edge
  a_r7_stop_low: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !level);

  // R7: a freshly started counter begins in the low phase
  a_r7_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |=> !level);

  // R3: completing a period returns the output to low
  a_r3_done_ends_high: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |=> !level);

endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int unsigned CW     = 8,
  parameter int unsigned MAXLOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CW-1:0]     busWdata,
  output logic [CW-1:0]     busRdata,
  input  logic [CW-1:0]     low0,
  input  logic [CW-1:0]     high0,
  input  logic [CW-1:0]     low1,
  input  logic [CW-1:0]     high1,
  input  logic              done0,
  input  logic              done1,
  output ppgStrobe_t        strb,
  output logic              irq0,
  output logic              irq1
);

  localparam int unsigned SELW = 3;

  logic            en0, en1, oe0, oe1, ie0, ie1;
  ppgMode_e        modeReg;
  ppgMode_e        effMode;
  logic [SELW-1:0] clkSel;
  logic [SELW-1:0] effSel;
  logic [1:0]      flags;
  logic [1:0]      flagClr;
  logic [MAXLOG-1:0] divCnt;
  logic [MAXLOG-1:0] tickMask;
  logic            anyRun;
  logic            baseTick;
  logic [CW-1:0]   rdNext;

  assign anyRun  = en0 || en1;
  assign effMode = (modeReg == MODE_RSVD) ? MODE_SPLIT : modeReg;
  assign effSel  = (clkSel > SELW'(MAXLOG)) ? SELW'(MAXLOG) : clkSel;
  assign flagClr = (busWe && busAddr == ADDR_FLAGS) ? busWdata[1:0] : 2'b00;

  always_comb begin
    for (int i = 0; i < MAXLOG; i++) begin
      tickMask[i] = (SELW'(i) < effSel);
    end
  end

  assign baseTick = anyRun && ((divCnt & tickMask) == tickMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en0     <= 1'b0;
      en1     <= 1'b0;
      oe0     <= 1'b0;
      oe1     <= 1'b0;
      modeReg <= MODE_SPLIT;
      clkSel  <= '0;
      ie0     <= 1'b0;
      ie1     <= 1'b0;
    end else if (busWe) begin
      if (busAddr == ADDR_CTRL) begin
        en0     <= busWdata[0];
        en1     <= busWdata[1];
        oe0     <= busWdata[2];
        oe1     <= busWdata[3];
        modeReg <= ppgMode_e'(busWdata[5:4]);
      end
      if (busAddr == ADDR_CFG) begin
        clkSel <= busWdata[SELW-1:0];
        ie0    <= busWdata[3];
        ie1    <= busWdata[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= 2'b00;
    end else begin
      flags <= (flags & ~flagClr) | {done1, done0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !anyRun) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + MAXLOG'(1);
    end
  end

  always_comb begin
    rdNext = '0;
    case (busAddr)
      ADDR_CTRL:  rdNext[5:0] = {modeReg, oe1, oe0, en1, en0};
      ADDR_CFG:   rdNext[4:0] = {ie1, ie0, clkSel};
      ADDR_LOW0:  rdNext = low0;
      ADDR_HIGH0: rdNext = high0;
      ADDR_LOW1:  rdNext = low1;
      ADDR_HIGH1: rdNext = high1;
      ADDR_FLAGS: rdNext[1:0] = flags;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  always_comb begin
    strb          = '0;
    strb.run0     = en0 && (effMode == MODE_SPLIT);
    strb.run1     = en1;
    strb.oe0      = oe0;
    strb.oe1      = oe1;
    strb.baseTick = baseTick;
    strb.mode     = effMode;
    strb.wrLow0   = busWe && (busAddr == ADDR_LOW0);
    strb.wrHigh0  = busWe && (busAddr == ADDR_HIGH0);
    strb.wrLow1   = busWe && (busAddr == ADDR_LOW1);
    strb.wrHigh1  = busWe && (busAddr == ADDR_HIGH1);
  end

  assign irq0 = flags[0] && ie0;
  assign irq1 = flags[1] && ie1;

  // R6: with any divide above one, ticks never come on consecutive cycles
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (baseTick && clkSel != '0) |=> (!baseTick || !$stable(clkSel)));

  // R10: a period end from the datapath always lands in the flag
  a_r10_flag0_set: assert property (@(posedge clk) disable iff (!rstN)
    done0 |=> flags[0]);

  a_r10_flag1_set: assert property (@(posedge clk) disable iff (!rstN)
    done1 |=> flags[1]);

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ppgStrobe_t    strb,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] low0,
  output logic [CW-1:0] high0,
  output logic [CW-1:0] low1,
  output logic [CW-1:0] high1,
  output logic          pwm0,
  output logic          pwm1,
  output logic          done0,
  output logic          done1
);

  localparam int unsigned WW = 2 * CW;

  logic [CW-1:0] preCnt;
  logic          presc;
  logic          preTick;
  logic          levelA, levelB;
  logic [WW-1:0] lowB, highB;
  logic          tickB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      low0  <= '0;
      high0 <= '0;
      low1  <= '0;
      high1 <= '0;
    end else begin
      if (strb.wrLow0)  low0  <= wdata;
      if (strb.wrHigh0) high0 <= wdata;
      if (strb.wrLow1)  low1  <= wdata;
      if (strb.wrHigh1) high1 <= wdata;
    end
  end

  assign presc   = (strb.mode == MODE_PRESC) && strb.run1;
  assign preTick = presc && strb.baseTick && (preCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!presc) begin
      preCnt <= low0;
    end else if (strb.baseTick) begin
      preCnt <= (preCnt == '0) ? low0 : preCnt - CW'(1);
    end
  end

  always_comb begin
    if (strb.mode == MODE_WIDE) begin
      lowB  = {low1, low0};
      highB = {high1, high0};
    end else begin
      lowB  = {{CW{1'b0}}, low1};
      highB = {{CW{1'b0}}, high1};
    end
    tickB = (strb.mode == MODE_PRESC) ? preTick : strb.baseTick;
  end

  ppg_counter #(.W(CW)) uCntA (
    .clk        (clk),
    .rstN       (rstN),
    .run        (strb.run0),
    .tick       (strb.baseTick),
    .lowVal     (low0),
    .highVal    (high0),
    .level      (levelA),
    .periodDone (done0)
  );

  ppg_counter #(.W(WW)) uCntB (
    .clk        (clk),
    .rstN       (rstN),
    .run        (strb.run1),
    .tick       (tickB),
    .lowVal     (lowB),
    .highVal    (highB),
    .level      (levelB),
    .periodDone (done1)
  );

  assign pwm0 = levelA && strb.oe0;
  assign pwm1 = levelB && strb.oe1;

  // R4: when the pair is joined, output 0 goes quiet
  a_r4_out0_idle: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mode != MODE_SPLIT) |=> !pwm0);

  // R5: the prescaled counter never advances twice in a row unless divide is one
  a_r5_pre_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (preTick && low0 != '0 && $stable(low0)) |=> !preTick);

endmodule

// File: rtl/ppg_top.sv
module ppg_top
  import ppg_pkg::*;
#(
  parameter int unsigned CW     = 8,
  parameter int unsigned MAXLOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CW-1:0]     busWdata,
  output logic [CW-1:0]     busRdata,
  output logic              pwmOut0,
  output logic              pwmOut1,
  output logic              irq0,
  output logic              irq1
);

  ppgStrobe_t    strb;
  logic [CW-1:0] low0, high0, low1, high1;
  logic          done0, done1;

  ppg_ctrl #(.CW(CW), .MAXLOG(MAXLOG)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .low0     (low0),
    .high0    (high0),
    .low1     (low1),
    .high1    (high1),
    .done0    (done0),
    .done1    (done1),
    .strb     (strb),
    .irq0     (irq0),
    .irq1     (irq1)
  );

  ppg_datapath #(.CW(CW)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (busWdata),
    .low0  (low0),
    .high0 (high0),
    .low1  (low1),
    .high1 (high1),
    .pwm0  (pwmOut0),
    .pwm1  (pwmOut1),
    .done0 (done0),
    .done1 (done1)
  );

endmodule

// File: tb/tb_ppg_top.sv
module tb_ppg_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       pwmOut0, pwmOut1, irq0, irq1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ppg_top dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .pwmOut0(pwmOut0), .pwmOut1(pwmOut1), .irq0(irq0), .irq1(irq1)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busAddr = a;
    @(posedge clk); @(negedge clk);
    d = busRdata;
  endtask

  function automatic logic outOf(input int sel);
    return (sel == 0) ? pwmOut0 : pwmOut1;
  endfunction

  task automatic waitLevel(input int sel, input logic v, input string req);
    int n = 0;
    while (outOf(sel) !== v && n < 20000) begin
      @(negedge clk); n++;
    end
    if (n >= 20000) check(req, "output level timeout", 0, 1);
  endtask

  task automatic highLen(input int sel, input string req, output int hi);
    waitLevel(sel, 1'b0, req);
    waitLevel(sel, 1'b1, req);
    hi = 0;
    while (outOf(sel) === 1'b1 && hi < 20000) begin
      hi++; @(negedge clk);
    end
  endtask

  task automatic measure(input int sel, input string req, output int lo, output int hi);
    highLen(sel, req, hi);
    lo = 0;
    while (outOf(sel) === 1'b0 && lo < 20000) begin
      lo++; @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lo, hi, div, sawHigh;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "pwmOut0", pwmOut0, 0);
    check("R1", "pwmOut1", pwmOut1, 0);
    check("R1", "irq0", irq0, 0);
    check("R1", "irq1", irq1, 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check("R1", $sformatf("reg %0d", a), d, 0);
    end

    // R2: readback and masking
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2", "ctrl readback", d, 8'h3F);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R2", "cfg readback", d, 8'h1F);
    wr(3'd2, 8'hA5); rd(3'd2, d); check("R2", "low0", d, 8'hA5);
    wr(3'd3, 8'h5A); rd(3'd3, d); check("R2", "high0", d, 8'h5A);
    wr(3'd4, 8'h3C); rd(3'd4, d); check("R2", "low1", d, 8'h3C);
    wr(3'd5, 8'hC3); rd(3'd5, d); check("R2", "high1", d, 8'hC3);
    wr(3'd6, 8'h03);

    // R3 / R6: split-mode sweep over clock select and widths
    for (int sel = 0; sel < 6; sel++) begin
      for (int li = 0; li < 3; li++) begin
        for (int hj = 0; hj < 3; hj++) begin
          int lv = (li == 0) ? 0 : (li == 1) ? 2 : 5;
          int hv = (hj == 0) ? 0 : (hj == 1) ? 1 : 4;
          div = 1 << ((sel > 4) ? 4 : sel);
          wr(3'd0, 8'h00);
          wr(3'd1, 8'(sel));
          wr(3'd2, 8'(lv));
          wr(3'd3, 8'(hv));
          wr(3'd0, 8'h05);
          measure(0, "R3", lo, hi);
          check("R6", $sformatf("low sel%0d L%0d H%0d", sel, lv, hv), lo, (lv + 1) * div);
          check("R3", $sformatf("high sel%0d L%0d H%0d", sel, lv, hv), hi, (hv + 1) * div);
        end
      end
    end

    // R3: both channels at once, independent; mode 3 acts as split
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'd2); wr(3'd3, 8'd1); wr(3'd4, 8'd4); wr(3'd5, 8'd6);
    wr(3'd0, 8'h3F);
    measure(1, "R3", lo, hi);
    check("R3", "ch1 low concurrent", lo, 10);
    check("R3", "ch1 high concurrent", hi, 14);
    measure(0, "R3", lo, hi);
    check("R3", "ch0 low concurrent", lo, 6);
    check("R3", "ch0 high concurrent", hi, 4);

    // R4: wide mode
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h02); wr(3'd4, 8'h01); wr(3'd3, 8'h05); wr(3'd5, 8'h00);
    wr(3'd0, 8'h1F);
    measure(1, "R4", lo, hi);
    check("R4", "wide low", lo, 259);
    check("R4", "wide high", hi, 6);
    sawHigh = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwmOut0) sawHigh = 1;
      @(negedge clk);
    end
    check("R4", "out0 idle in wide mode", sawHigh, 0);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h01);
    wr(3'd0, 8'h1A);
    measure(1, "R4", lo, hi);
    check("R4", "wide low minimal", lo, 1);
    check("R4", "wide high 257", hi, 257);

    // R5: prescaled mode
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'd2); wr(3'd3, 8'd7); wr(3'd4, 8'd3); wr(3'd5, 8'd1);
    wr(3'd0, 8'h2A);
    measure(1, "R5", lo, hi);
    check("R5", "prescaled low", lo, 24);
    check("R5", "prescaled high", hi, 12);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'd0); wr(3'd4, 8'd1); wr(3'd5, 8'd2);
    wr(3'd0, 8'h2A);
    measure(1, "R5", lo, hi);
    check("R5", "prescale by one low", lo, 2);
    check("R5", "prescale by one high", hi, 3);

    // R7: starts low, disable forces low
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'd50); wr(3'd3, 8'd50);
    wr(3'd0, 8'h05);
    sawHigh = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwmOut0) sawHigh = 1;
      @(negedge clk);
    end
    check("R7", "output low after enable", sawHigh, 0);
    waitLevel(0, 1'b1, "R7");
    check("R7", "reached high phase", pwmOut0, 1);
    wr(3'd0, 8'h04);
    @(negedge clk);
    check("R7", "output low after disable", pwmOut0, 0);

    // R8: output enable off, counter still runs
    wr(3'd0, 8'h00);
    wr(3'd2, 8'd3); wr(3'd3, 8'd3);
    wr(3'd6, 8'h03);
    wr(3'd0, 8'h01);
    sawHigh = 0;
    for (int i = 0; i < 200; i++) begin
      if (pwmOut0) sawHigh = 1;
      @(negedge clk);
    end
    check("R8", "output masked", sawHigh, 0);
    rd(3'd6, d);
    check("R8", "flag0 set while masked", d[0], 1);

    // R9: high width change applies from next period
    wr(3'd0, 8'h00);
    wr(3'd2, 8'd20); wr(3'd3, 8'd3);
    wr(3'd0, 8'h05);
    waitLevel(0, 1'b1, "R9");
    waitLevel(0, 1'b0, "R9");
    wr(3'd3, 8'd9);
    highLen(0, "R9", hi);
    check("R9", "high after mid-period write", hi, 4);
    waitLevel(0, 1'b1, "R9");
    hi = 0;
    while (pwmOut0 === 1'b1 && hi < 20000) begin
      hi++; @(negedge clk);
    end
    check("R9", "high in following period", hi, 10);

    // R10: flags and interrupts
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h08);
    wr(3'd2, 8'd100); wr(3'd3, 8'd100);
    wr(3'd6, 8'h03);
    check("R10", "irq0 after clear", irq0, 0);
    wr(3'd0, 8'h05);
    waitLevel(0, 1'b1, "R10");
    waitLevel(0, 1'b0, "R10");
    check("R10", "irq0 at period end", irq0, 1);
    check("R10", "irq1 masked", irq1, 0);
    rd(3'd6, d);
    check("R10", "flag0 set", d[0], 1);
    wr(3'd6, 8'h01);
    check("R10", "irq0 cleared", irq0, 0);
    rd(3'd6, d);
    check("R10", "flag0 cleared", d[0], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule